// File: doc/BRIEF.md
# Multiply/Divide Issue Controller

This block sits in front of an integer multiply/divide datapath. A requester presents an operation tagged with a thread number and a sequence number. The controller places each accepted operation in one of a few slots and counts down a latency. For a multiply the latency is fixed. For a divide it is taken from the byte size of the divisor. When the countdown expires, the slot latches the product, or the quotient and remainder. The requester then collects the result with a poll or an end command.

New operations are throttled by a minimum spacing that depends on the type of the most recently accepted operation and, for a divide, on its size class. Requests that arrive already faulted pass straight through. A squash removes every operation of one thread that is younger than a given sequence number. A squashed operation that is still counting keeps its slot until its countdown ends. The unit also counts the multiplies and divides it completes.

Responses are combinational in the request cycle. State changes at the next rising edge.

Top module: `mdu_issue_ctl`

## Requirements
- R1: After reset no slot is held and both completion counters read zero. The first START request is granted at once, because no previous operation imposes a spacing.
- R2: A divide's size class comes from its divisor. Values up to 0xFF are class 8, up to 0xFFFF class 16, and up to 0xFFFFFF class 24. Larger values are class 32. Each class has its own latency and its own spacing.
- R3: A START accepted in cycle t with latency L is reported as not done by POLL or END in cycles t+1 to t+L-1. It is reported done in cycle t+L.
- R4: A START for a new operation in cycle t+k, after the last accepted start in cycle t, is granted only if k is at least the spacing of that last operation. The spacing is the multiply spacing after a multiply and the class spacing after a divide. A rejected request changes no state.
- R5: A START from an operation that already holds a slot returns that slot with grant, even while the spacing is in force. It neither restarts the countdown nor counts as a new issue for the spacing rule.
- R6: Command encoding on req_cmd is 0 = START, 1 = POLL, 2 = END, and 3 is reserved (never granted). An END on a slot that is still counting returns done=0 and keeps the slot. An END on a finished slot returns done=1 with the result and frees the slot from the next cycle. A POLL reports the same status but never frees the slot.
- R7: The results are unsigned. A multiply returns the product {resp_hi, resp_lo} = a*b. A divide returns the quotient a/b on resp_lo and the remainder a%b on resp_hi.
- R8: A divide by zero uses the class-32 latency and spacing. It returns all ones as the quotient and the dividend as the remainder.
- R9: A request with req_fault set returns done=1 and grant=0. It takes no slot, does not affect the spacing, and is not counted.
- R10: A squash for thread T and sequence S marks every held slot of thread T with a sequence number greater than S (unsigned compare) as squashed. Squashed slots no longer match requests. A finished slot is freed on the next cycle. A counting slot is freed when its countdown ends. Slots of other threads, and slots with sequence numbers at or below S, are untouched.
- R11: mul_count and div_count each rise by one for every multiply or divide whose countdown ends, squashed ones included.
- R12: A new operation takes the lowest-numbered free slot. With every slot held, a new START is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 2 | 0 START, 1 POLL, 2 END, 3 reserved |
| req_div | input | 1 | 1 = divide, 0 = multiply (used on START) |
| req_fault | input | 1 | Request carries an earlier fault |
| req_tid | input | TID_W | Thread number |
| req_sn | input | SN_W | Sequence number |
| req_a | input | W | Multiplicand or dividend |
| req_b | input | W | Multiplier or divisor |
| sq_valid | input | 1 | Squash this cycle |
| sq_tid | input | TID_W | Thread to squash |
| sq_sn | input | SN_W | Operations younger than this are squashed |
| resp_grant | output | 1 | Request accepted or matched to its slot |
| resp_done | output | 1 | Operation finished (or fault passed through) |
| resp_slot | output | $clog2(NSLOT) | Slot used by the request |
| resp_lo | output | W | Product low half or quotient |
| resp_hi | output | W | Product high half or remainder |
| slot_held | output | NSLOT | One bit per occupied slot |
| mul_count | output | CNT_W | Completed multiplies |
| div_count | output | CNT_W | Completed divides |

## Verification
The assertions assume that a request and a squash never target the same operation in one cycle. They also assume that the pair of thread and sequence number is unique among live operations, and that every configured latency is at least two. The stimulus issues requests and squashes in separate cycles. It gives each operation a fresh sequence number. It keeps the default latencies, which all exceed their spacing by at least two, so a second operation can always be issued before the first one finishes.

// File: rtl/mdu_issue_ctl.sv
module mdu_issue_ctl #(
  parameter int W        = 32,
  parameter int TID_W    = 2,
  parameter int SN_W     = 8,
  parameter int NSLOT    = 2,
  parameter int CNT_W    = 16,
  parameter int MUL_LAT  = 4,
  parameter int MUL_RATE = 2,
  parameter int D8_LAT   = 4,
  parameter int D8_RATE  = 2,
  parameter int D16_LAT  = 6,
  parameter int D16_RATE = 3,
  parameter int D24_LAT  = 8,
  parameter int D24_RATE = 4,
  parameter int D32_LAT  = 10,
  parameter int D32_RATE = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [1:0]               req_cmd,
  input  logic                     req_div,
  input  logic                     req_fault,
  input  logic [TID_W-1:0]         req_tid,
  input  logic [SN_W-1:0]          req_sn,
  input  logic [W-1:0]             req_a,
  input  logic [W-1:0]             req_b,
  input  logic                     sq_valid,
  input  logic [TID_W-1:0]         sq_tid,
  input  logic [SN_W-1:0]          sq_sn,
  output logic                     resp_grant,
  output logic                     resp_done,
  output logic [$clog2(NSLOT)-1:0] resp_slot,
  output logic [W-1:0]             resp_lo,
  output logic [W-1:0]             resp_hi,
  output logic [NSLOT-1:0]         slot_held,
  output logic [CNT_W-1:0]         mul_count,
  output logic [CNT_W-1:0]         div_count
);
  localparam int SW = $clog2(NSLOT);
  localparam int TW = 8;
  localparam logic [1:0] C_START = 2'd0, C_POLL = 2'd1, C_END = 2'd2;
  localparam logic [1:0] K_NONE = 2'd0, K_MUL = 2'd1, K_DIV = 2'd2;

  function automatic logic [TW-1:0] rate_of(input logic isdiv, input logic [1:0] c);
    if (!isdiv) return TW'(MUL_RATE);
    case (c)
      2'd0:    return TW'(D8_RATE);
      2'd1:    return TW'(D16_RATE);
      2'd2:    return TW'(D24_RATE);
      default: return TW'(D32_RATE);
    endcase
  endfunction

  function automatic logic [TW-1:0] lat_of(input logic isdiv, input logic [1:0] c);
    if (!isdiv) return TW'(MUL_LAT);
    case (c)
      2'd0:    return TW'(D8_LAT);
      2'd1:    return TW'(D16_LAT);
      2'd2:    return TW'(D24_LAT);
      default: return TW'(D32_LAT);
    endcase
  endfunction

  logic [NSLOT-1:0] v, busy, sqd, sdiv, hit, fin;
  logic [TID_W-1:0] s_tid [NSLOT];
  logic [SN_W-1:0]  s_sn  [NSLOT];
  logic [TW-1:0]    s_cnt [NSLOT];
  logic [W-1:0]     s_lo  [NSLOT];
  logic [W-1:0]     s_hi  [NSLOT];
  logic [W-1:0]     r_lo  [NSLOT];
  logic [W-1:0]     r_hi  [NSLOT];
  logic [2*W-1:0]   prod  [NSLOT];
  logic [1:0]       kind, lcls, ncls;
  logic [TW-1:0]    since, rate, nlat;
  logic [CNT_W-1:0] nm, nd;
  logic             hit_any, free_any, live, new_start, accept, end_free;
  logic [SW-1:0]    hit_idx, free_idx;

  assign ncls = (req_b == '0 || |(req_b >> 24)) ? 2'd3 :
                |(req_b >> 16) ? 2'd2 :
                |(req_b >> 8)  ? 2'd1 : 2'd0;
  assign rate = (kind == K_NONE) ? '0 : rate_of(kind == K_DIV, lcls);
  assign nlat = lat_of(req_div, ncls);

  always_comb begin
    hit_any  = 1'b0;
    free_any = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      hit[i] = v[i] & ~sqd[i] & (s_tid[i] == req_tid) & (s_sn[i] == req_sn);
      fin[i] = busy[i] & (s_cnt[i] == TW'(1));
      if (hit[i]) begin hit_any = 1'b1; hit_idx = SW'(i); end
      if (!v[i])  begin free_any = 1'b1; free_idx = SW'(i); end
    end
  end

  always_comb begin
    nm = '0;
    nd = '0;
    for (int i = 0; i < NSLOT; i++) begin
      prod[i] = {{W{1'b0}}, s_lo[i]} * {{W{1'b0}}, s_hi[i]};
      if (sdiv[i]) begin
        if (s_hi[i] == '0) begin
          r_lo[i] = '1;
          r_hi[i] = s_lo[i];
        end else begin
          r_lo[i] = s_lo[i] / s_hi[i];
          r_hi[i] = s_lo[i] % s_hi[i];
        end
      end else begin
        r_lo[i] = prod[i][W-1:0];
        r_hi[i] = prod[i][2*W-1:W];
      end
      nm = nm + CNT_W'(fin[i] & ~sdiv[i]);
      nd = nd + CNT_W'(fin[i] & sdiv[i]);
    end
  end

  assign live      = req_valid & ~req_fault;
  assign new_start = live & (req_cmd == C_START) & ~hit_any;
  assign accept    = new_start & free_any & (since >= rate);
  assign end_free  = live & (req_cmd == C_END) & hit_any & ~busy[hit_idx];

  assign resp_grant = accept | (live & hit_any & (req_cmd != 2'd3));
  assign resp_slot  = hit_any ? hit_idx : free_idx;
  assign resp_done  = req_valid & (req_fault |
                      (hit_any & ~busy[hit_idx] & (req_cmd == C_POLL || req_cmd == C_END)));
  assign resp_lo    = (live & resp_done) ? s_lo[hit_idx] : '0;
  assign resp_hi    = (live & resp_done) ? s_hi[hit_idx] : '0;
  assign slot_held  = v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0; busy <= '0; sqd <= '0; sdiv <= '0;
      kind <= K_NONE; lcls <= 2'd0; since <= '1;
      mul_count <= '0; div_count <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        s_tid[i] <= '0; s_sn[i] <= '0; s_cnt[i] <= '0;
        s_lo[i] <= '0;  s_hi[i] <= '0;
      end
    end else begin
      since <= accept ? TW'(1) : ((since == '1) ? since : since + TW'(1));
      if (accept) begin
        kind <= req_div ? K_DIV : K_MUL;
        if (req_div) lcls <= ncls;
      end
      mul_count <= mul_count + nm;
      div_count <= div_count + nd;
      for (int i = 0; i < NSLOT; i++) begin
        if (accept && free_idx == SW'(i)) begin
          v[i] <= 1'b1; busy[i] <= 1'b1; sqd[i] <= 1'b0; sdiv[i] <= req_div;
          s_tid[i] <= req_tid; s_sn[i] <= req_sn; s_cnt[i] <= nlat - TW'(1);
          s_lo[i] <= req_a; s_hi[i] <= req_b;
        end else begin
          if (busy[i]) begin
            s_cnt[i] <= s_cnt[i] - TW'(1);
            if (fin[i]) begin
              busy[i] <= 1'b0;
              s_lo[i] <= r_lo[i];
              s_hi[i] <= r_hi[i];
              if (sqd[i]) v[i] <= 1'b0;
            end
          end
          if (end_free && hit_idx == SW'(i)) v[i] <= 1'b0;
          if (sq_valid && v[i] && s_tid[i] == sq_tid && s_sn[i] > sq_sn) begin
            sqd[i] <= 1'b1;
            if (!busy[i] || fin[i]) v[i] <= 1'b0;
          end
        end
      end
    end
  end

  logic [TW-1:0] ck_gap, ck_need;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_gap  <= '1;
      ck_need <= '0;
    end else if (accept) begin
      ck_gap  <= TW'(1);
      ck_need <= rate_of(req_div, ncls);
    end else if (ck_gap != '1) begin
      ck_gap <= ck_gap + TW'(1);
    end
  end

  a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ck_gap >= ck_need);
  a_r12_alloc_held: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> slot_held[$past(resp_slot)]);
  a_r6_end_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && req_cmd == C_END && !req_fault) |=> !slot_held[$past(hit_idx)]);
  a_r9_fault_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fault) |=>
      since == (($past(since) == '1) ? '1 : $past(since) + TW'(1)));
  a_r5_repeat_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
    (live && req_cmd == C_START && hit_any) |=> since != TW'(1));
  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(mul_count - $past(mul_count)) + CNT_W'(div_count - $past(div_count)) <= CNT_W'(NSLOT));
endmodule

// File: tb/sim_mdu_issue_ctl.sv
`timescale 1ns/1ps
module sim_mdu_issue_ctl;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_div = 0, req_fault = 0, sq_valid = 0;
  logic [1:0] req_cmd = 0;
  logic [1:0] req_tid = 0, sq_tid = 0;
  logic [7:0] req_sn = 0, sq_sn = 0;
  logic [31:0] req_a = 0, req_b = 0;
  logic resp_grant, resp_done;
  logic [0:0] resp_slot;
  logic [31:0] resp_lo, resp_hi;
  logic [1:0] slot_held;
  logic [15:0] mul_count, div_count;

  always #2.5 clk = ~clk;

  mdu_issue_ctl #(.W(32), .TID_W(2), .SN_W(8), .NSLOT(2), .CNT_W(16),
    .MUL_LAT(4), .MUL_RATE(2), .D8_LAT(4), .D8_RATE(2), .D16_LAT(6), .D16_RATE(3),
    .D24_LAT(8), .D24_RATE(4), .D32_LAT(10), .D32_RATE(5)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_div(req_div), .req_fault(req_fault), .req_tid(req_tid), .req_sn(req_sn),
    .req_a(req_a), .req_b(req_b), .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_sn(sq_sn),
    .resp_grant(resp_grant), .resp_done(resp_done), .resp_slot(resp_slot),
    .resp_lo(resp_lo), .resp_hi(resp_hi), .slot_held(slot_held),
    .mul_count(mul_count), .div_count(div_count));

  int cyc = 0, checks = 0, fails = 0, rc = 0;
  int exp_mul = 0, exp_div = 0;
  logic g, d, sl;
  logic [31:0] lo, hi;
  logic [1:0] hd;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, expv, rc);
    end
  endtask

  task automatic rq(input logic [1:0] cmd, input logic dv, input logic flt,
                    input logic [1:0] tid, input logic [7:0] sn,
                    input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_div = dv; req_fault = flt;
    req_tid = tid; req_sn = sn; req_a = a; req_b = b; sq_valid = 0;
    #1;
    rc = cyc; g = resp_grant; d = resp_done; sl = resp_slot;
    lo = resp_lo; hi = resp_hi; hd = slot_held;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; sq_valid = 0;
      #1;
      rc = cyc; hd = slot_held;
    end
  endtask

  task automatic sq(input logic [1:0] tid, input logic [7:0] sn);
    @(negedge clk);
    req_valid = 0; sq_valid = 1; sq_tid = tid; sq_sn = sn;
    #1;
    rc = cyc; hd = slot_held;
  endtask

  task automatic wait_done(input logic [1:0] cmd, input logic [1:0] tid, input logic [7:0] sn);
    int n = 0;
    do begin rq(cmd, 0, 0, tid, sn, 0, 0); n++; end while (!d && n < 40);
  endtask

  function automatic int cls_of(input logic [31:0] b);
    if (b == 0) return 3;
    if (b <= 32'hFF) return 0;
    if (b <= 32'hFFFF) return 1;
    if (b <= 32'hFFFFFF) return 2;
    return 3;
  endfunction
  function automatic int lat_c(input int c);
    return (c == 0) ? 4 : (c == 1) ? 6 : (c == 2) ? 8 : 10;
  endfunction
  function automatic int rate_c(input int c);
    return c + 2;
  endfunction
  function automatic logic [31:0] div_b(input int k);
    case (k)
      1: return 32'h0;        2: return 32'h1;       3: return 32'hFF;
      4: return 32'h100;      5: return 32'hFFFF;    6: return 32'h10000;
      7: return 32'hFFFFFF;   8: return 32'h1000000; default: return 32'hFFFFFFFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int ta, n, lat, rt;
    logic [31:0] a, b, eq, er;
    logic [63:0] p;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle(1);
    chk(hd == 2'b00, "R1 slots empty after reset", hd, 0);
    chk(mul_count == 0 && div_count == 0, "R1 counters zero after reset",
        {mul_count, div_count}, 0);

    // Sweep: multiply plus every divide size class boundary
    for (int k = 0; k < 10; k++) begin
      logic isdiv;
      isdiv = (k != 0);
      a = isdiv ? 32'hDEADBEEF : 32'h0012_3457;
      b = isdiv ? div_b(k) : 32'h0000_6789;
      lat = isdiv ? lat_c(cls_of(b)) : 4;
      rt  = isdiv ? rate_c(cls_of(b)) : 2;
      idle(12);
      rq(0, isdiv, 0, 0, 8'(2*k+1), a, b);
      chk(g == 1, (k == 0) ? "R1 first start granted" : "R12 start granted", g, 1);
      chk(sl == 0, "R12 lowest free slot", sl, 0);
      ta = rc;
      n = 0;
      do begin rq(0, 0, 0, 0, 8'(2*k+2), 3, 5); n++; end while (!g && n < 20);
      chk(rc - ta == rt, isdiv ? "R2 R4 spacing after divide class" : "R4 spacing after multiply",
          rc - ta, rt);
      chk(sl == 1, "R12 second slot used", sl, 1);
      wait_done(1, 0, 8'(2*k+1));
      chk(rc - ta == lat, isdiv ? "R2 R3 divide class latency" : "R3 multiply latency",
          rc - ta, lat);
      rq(2, 0, 0, 0, 8'(2*k+1), 0, 0);
      if (isdiv) begin
        eq = (b == 0) ? 32'hFFFFFFFF : a / b;
        er = (b == 0) ? a : a % b;
        chk(d == 1 && lo == eq, (b == 0) ? "R8 zero divisor quotient" : "R7 quotient", lo, eq);
        chk(hi == er, (b == 0) ? "R8 zero divisor remainder" : "R7 remainder", hi, er);
        exp_div++;
      end else begin
        p = 64'(a) * 64'(b);
        chk(d == 1 && {hi, lo} == p, "R7 product", {hi, lo}, p);
        exp_mul++;
      end
      wait_done(2, 0, 8'(2*k+2));
      chk(lo == 15 && hi == 0, "R7 small product", {hi, lo}, 15);
      exp_mul++;
      idle(1);
      chk(hd == 2'b00, "R6 END frees slot", hd, 0);
    end
    chk(mul_count == 16'(exp_mul), "R11 multiply count", mul_count, exp_mul);
    chk(div_count == 16'(exp_div), "R11 divide count", div_count, exp_div);

    // R5: repeated START from a slot holder
    idle(12);
    rq(0, 1, 0, 1, 100, 1000, 7);
    ta = rc;
    rq(0, 1, 0, 1, 100, 1000, 7);
    chk(g == 1 && sl == 0, "R5 repeat start returns own slot", {g, sl}, 2'b10);
    rq(0, 0, 0, 1, 101, 2, 9);
    chk(g == 1, "R5 repeat start not charged to spacing", g, 1);
    rq(1, 0, 0, 1, 100, 0, 0);
    chk(d == 0, "R3 R6 poll before latency not done", d, 0);
    wait_done(1, 1, 100);
    chk(rc - ta == 4, "R5 countdown not restarted", rc - ta, 4);
    rq(2, 0, 0, 1, 100, 0, 0);
    chk(lo == 142 && hi == 6, "R7 divide result", {hi, lo}, {32'd6, 32'd142});
    wait_done(2, 1, 101);
    chk(lo == 18, "R7 product after repeat", lo, 18);
    exp_div++; exp_mul++;

    // R9: faulted request passes through
    idle(12);
    rq(0, 0, 0, 2, 1, 4, 4);
    rq(0, 0, 1, 2, 2, 9, 9);
    chk(d == 1 && g == 0, "R9 fault done without grant", {d, g}, 2'b10);
    rq(0, 0, 0, 2, 3, 5, 5);
    chk(g == 1, "R9 fault not charged to spacing", g, 1);
    chk(hd == 2'b01, "R9 fault took no slot", hd, 2'b01);
    wait_done(2, 2, 1);
    chk(lo == 16, "R7 product 4*4", lo, 16);
    wait_done(2, 2, 3);
    chk(lo == 25, "R7 product 5*5", lo, 25);
    exp_mul += 2;
    chk(mul_count == 16'(exp_mul), "R9 R11 fault not counted", mul_count, exp_mul);

    // R10: squash of a finished and a counting slot
    idle(12);
    rq(0, 0, 0, 1, 5, 6, 7);
    idle(6);
    rq(0, 1, 0, 1, 9, 100, 0);
    ta = rc;
    chk(g == 1 && sl == 1, "R12 second slot for divide", {g, sl}, 2'b11);
    sq(1, 4);
    rq(1, 0, 0, 1, 9, 0, 0);
    chk(g == 0, "R10 squashed slot does not match", g, 0);
    chk(hd == 2'b10, "R10 idle freed, counting kept", hd, 2'b10);
    while (rc < ta + 9) idle(1);
    chk(hd == 2'b10, "R10 counting slot held until end", hd, 2'b10);
    idle(1);
    chk(hd == 2'b00, "R10 counting slot freed at end", hd, 0);
    exp_mul++; exp_div++;
    idle(1);
    chk(div_count == 16'(exp_div), "R11 squashed divide counted", div_count, exp_div);

    // R10 non-matching squash, R6 END while counting, R12 full
    idle(12);
    rq(0, 0, 0, 0, 50, 11, 13);
    rq(2, 0, 0, 0, 50, 0, 0);
    chk(d == 0 && g == 1, "R6 END while counting not done", {d, g}, 2'b01);
    rq(0, 1, 0, 1, 3, 50, 3);
    chk(g == 1, "R4 start after multiply spacing", g, 1);
    sq(1, 3);
    idle(1);
    chk(hd == 2'b11, "R10 older and other-thread slots kept", hd, 2'b11);
    idle(4);
    rq(0, 0, 0, 2, 7, 1, 1);
    chk(g == 0, "R12 full unit refuses start", g, 0);
    wait_done(2, 0, 50);
    chk(lo == 143, "R6 R7 END returns product", lo, 143);
    wait_done(2, 1, 3);
    chk(lo == 16 && hi == 2, "R6 R7 END returns quotient", {hi, lo}, {32'd2, 32'd16});
    exp_mul++; exp_div++;
    idle(1);
    chk(mul_count == 16'(exp_mul) && div_count == 16'(exp_div), "R11 final counts",
        {mul_count, div_count}, {16'(exp_mul), 16'(exp_div)});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule